// File: doc/BRIEF.md
# Modulo Timer with Prescaler

A 16-bit up-counting timer behind a simple 32-bit register port. The count clock is the block clock divided by a power of two chosen by a 3-bit prescale field, and counting happens only while the count-source field selects the system clock. The counter starts from a programmable start value and climbs to a programmable limit. On the count after the limit it returns to the start value and sets a wrap flag. The flag can drive a level interrupt.

Software sets up a period of N counts by writing a limit of N-1 with a start value of 0. The limit and start registers are double buffered. A write first lands in a holding copy. That copy reaches the working register only while the count source is switched off, so a running period is never disturbed. A write of any data to the counter register reloads it from the working start value.

Top module: `modulo_timer`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: Control sits at 0x00, counter at 0x04, limit at 0x08 and start at 0x4C. In control, bits [2:0] hold the prescale `p`, bits [4:3] the count source, bit 6 the interrupt enable and bit 7 the wrap flag. All other bits read 0. Counter, limit and start keep 16 bits and read back zero-extended.
- R3: With source 1, the counter advances once every 2^p clocks. The first advance comes 2^p clocks after the control write.
- R4: A count taken while the counter equals the working limit loads the working start value and sets the wrap flag. Otherwise a count adds 1, modulo 2^16.
- R5: With any source other than 1, the counter holds its value.
- R6: A write of any data to the counter loads the working start value. This takes priority over counting.
- R7: Limit and start writes go to holding copies. The working copies, which are what reads return, take the held value only on a clock edge where the source was 0 in the cycle before. A write made while the source is 0 is working at once.
- R8: A control write with bit 7 = 0 clears the wrap flag. A control write with bit 7 = 1 leaves the flag unchanged.
- R9: `irq_o` is high exactly while the wrap flag and the interrupt enable are both set.
- R10: Every control write restarts the prescale divider from zero, and no count is taken in the cycle of that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, together with `bus_sel_i` |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 1 | Wrap interrupt, level |

## Verification
The count function is driven with vectors that vary the prescale, the limit, the start value and the run length. Some runs stop just short of a wrap and others just past it, which separates an off-by-one limit compare from a correct one. One run starts above zero and one sits at the top of the 16-bit range, which shows whether the reload uses the start value and whether the compare is full width. The slowest prescale setting and a mid-period rewrite of control show whether the divider period is 2^p and whether it restarts on a control write. Writes to the limit register made while the timer is held at a non-zero source, followed by a read-back before and after the source is cleared, separate buffered commitment from direct writes.

// File: rtl/modtmr_pkg.sv
package modtmr_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned SRC_W  = 2;

  typedef enum logic [SRC_W-1:0] {
    SRC_OFF  = 2'd0,
    SRC_SYS  = 2'd1,
    SRC_RSV2 = 2'd2,
    SRC_RSV3 = 2'd3
  } src_e;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_LIMIT = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_START = 8'h4C;

  // control bit positions
  localparam int unsigned CTL_SRC_LO = 3;
  localparam int unsigned CTL_IE     = 6;
  localparam int unsigned CTL_FLAG   = 7;

  localparam int unsigned SHD_LIMIT = 0;
  localparam int unsigned SHD_START = 1;
  localparam int unsigned SHD_N     = 2;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PSC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  localparam int unsigned DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;

  assign lim    = ~({DIV_W{1'b1}} << psc_i);
  assign tick_o = run_i && !restart_i && (div_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  div_q <= '0;
    else if (restart_i || !run_i) div_q <= '0;
    else if (tick_o)              div_q <= '0;
    else                          div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tmr_shadow.sv
module tmr_shadow #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         load_i,
  output logic [W-1:0] act_o
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      act_o  <= '0;
    end else begin
      if (wr_i)   hold_q <= wdata_i;
      // a write during a stopped cycle is working at once
      if (load_i) act_o  <= wr_i ? wdata_i : hold_q;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         reload_i,
  input  logic [W-1:0] limit_i,
  input  logic [W-1:0] start_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic at_limit;

  assign at_limit = (cnt_o == limit_i);
  assign wrap_o   = tick_i && !reload_i && at_limit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_o <= '0;
    else if (reload_i) cnt_o <= start_i;
    else if (tick_i)   cnt_o <= at_limit ? start_i : cnt_o + 1'b1;
  end
endmodule

// File: rtl/modulo_timer.sv
module modulo_timer
  import modtmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              irq_o
);
  localparam int unsigned PAD_W = BUS_W - CNT_W;

  logic             wr;
  logic             ctrl_wr, cnt_wr;
  logic [SHD_N-1:0] shd_wr;
  logic [PSC_W-1:0] psc_q;
  src_e             src_q;
  logic             ie_q, flag_q;
  logic             tick, wrap;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] act [SHD_N];
  logic [CNT_W-1:0] limit_act, start_act;
  logic [PAD_W-1:0] unused_wdata_hi;

  assign wr      = bus_sel_i && bus_we_i;
  assign ctrl_wr = wr && (bus_addr_i == OFS_CTRL);
  assign cnt_wr  = wr && (bus_addr_i == OFS_COUNT);
  assign shd_wr[SHD_LIMIT] = wr && (bus_addr_i == OFS_LIMIT);
  assign shd_wr[SHD_START] = wr && (bus_addr_i == OFS_START);
  assign unused_wdata_hi   = bus_wdata_i[BUS_W-1:CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q <= '0;
      src_q <= SRC_OFF;
      ie_q  <= 1'b0;
    end else if (ctrl_wr) begin
      psc_q <= bus_wdata_i[PSC_W-1:0];
      src_q <= src_e'(bus_wdata_i[CTL_SRC_LO +: SRC_W]);
      ie_q  <= bus_wdata_i[CTL_IE];
    end
  end

  // flag: set on wrap, cleared only by writing 0 to its bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              flag_q <= 1'b0;
    else if (wrap)                            flag_q <= 1'b1;
    else if (ctrl_wr && !bus_wdata_i[CTL_FLAG]) flag_q <= 1'b0;
  end

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (src_q == SRC_SYS),
    .restart_i(ctrl_wr),
    .psc_i    (psc_q),
    .tick_o   (tick)
  );

  for (genvar g = 0; g < SHD_N; g++) begin : g_shd
    tmr_shadow #(.W(CNT_W)) u_shd (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (shd_wr[g]),
      .wdata_i(bus_wdata_i[CNT_W-1:0]),
      .load_i (src_q == SRC_OFF),
      .act_o  (act[g])
    );
  end

  assign limit_act = act[SHD_LIMIT];
  assign start_act = act[SHD_START];

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .reload_i(cnt_wr),
    .limit_i (limit_act),
    .start_i (start_act),
    .cnt_o   (cnt_q),
    .wrap_o  (wrap)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      OFS_CTRL: begin
        bus_rdata_o[PSC_W-1:0]               = psc_q;
        bus_rdata_o[CTL_SRC_LO +: SRC_W]     = src_q;
        bus_rdata_o[CTL_IE]                  = ie_q;
        bus_rdata_o[CTL_FLAG]                = flag_q;
      end
      OFS_COUNT: bus_rdata_o = {{PAD_W{1'b0}}, cnt_q};
      OFS_LIMIT: bus_rdata_o = {{PAD_W{1'b0}}, limit_act};
      OFS_START: bus_rdata_o = {{PAD_W{1'b0}}, start_act};
      default:   bus_rdata_o = '0;
    endcase
  end

  assign irq_o = flag_q && ie_q;
endmodule

// File: rtl/modulo_timer_chk.sv
module modulo_timer_chk
  import modtmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick,
  input logic             wrap,
  input logic             cnt_wr,
  input src_e             src_q,
  input logic             flag_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] limit_act,
  input logic [CNT_W-1:0] start_act
);
  assert_tick_only_sys_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |-> (src_q == SRC_SYS));

  assert_wrap_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !cnt_wr && cnt_q == limit_act) |=> (cnt_q == $past(start_act)) && flag_q);

  assert_hold_when_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_q != SRC_SYS && !cnt_wr) |=> (cnt_q == $past(cnt_q)));

  assert_count_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> (cnt_q == $past(start_act)));

  assert_limit_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_q != SRC_OFF) |=> $stable(limit_act));

  assert_start_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_q != SRC_OFF) |=> $stable(start_act));

  assert_flag_from_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(wrap));
endmodule

bind modulo_timer modulo_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick     (tick),
  .wrap     (wrap),
  .cnt_wr   (cnt_wr),
  .src_q    (src_q),
  .flag_q   (flag_q),
  .cnt_q    (cnt_q),
  .limit_act(limit_act),
  .start_act(start_act)
);

// File: tb/modulo_timer_tb_top.sv
`timescale 1ns/1ps
module modulo_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  modulo_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  localparam logic [7:0] A_CTL = 8'h00, A_CNT = 8'h04, A_LIM = 8'h08, A_STA = 8'h4C;

  typedef struct packed {
    logic [2:0]  psc;
    logic        ie;
    logic [15:0] lim;
    logic [15:0] sta;
    logic [15:0] wait_n;
    logic [15:0] exp_cnt;
    logic        exp_flag;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 16'd9,     16'd0,     16'd5,   16'd5,     1'b0}, // just short of wrap
    '{3'd0, 1'b1, 16'd9,     16'd0,     16'd10,  16'd0,     1'b1}, // exactly at wrap
    '{3'd2, 1'b0, 16'd3,     16'd0,     16'd13,  16'd3,     1'b0},
    '{3'd2, 1'b0, 16'd3,     16'd0,     16'd16,  16'd0,     1'b1},
    '{3'd0, 1'b1, 16'd20,    16'd15,    16'd8,   16'd17,    1'b1}, // nonzero start
    '{3'd7, 1'b0, 16'd1,     16'd0,     16'd300, 16'd0,     1'b1}, // slowest prescale
    '{3'd3, 1'b1, 16'hFFFF,  16'hFFF0,  16'd200, 16'hFFF9,  1'b1}  // top of range
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(A_CTL, d); check("R1 ctrl", d, 32'h0);
    rd(A_CNT, d); check("R1 count", d, 32'h0);
    rd(A_LIM, d); check("R1 limit", d, 32'h0);
    rd(A_STA, d); check("R1 start", d, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;
    idle(2);

    // R3 R4 R9: vector table
    for (int i = 0; i < NV; i++) begin
      wr(A_CTL, 32'h0);
      wr(A_STA, {16'h0, VECS[i].sta});
      wr(A_LIM, {16'h0, VECS[i].lim});
      wr(A_CNT, 32'h0);
      wr(A_CTL, {24'h0, 1'b0, VECS[i].ie, 1'b0, 2'd1, VECS[i].psc});
      idle(int'(VECS[i].wait_n));
      rd(A_CNT, d); check("R3/R4 count", d, {16'h0, VECS[i].exp_cnt});
      rd(A_CTL, d); check("R4 flag", {31'h0, d[7]}, {31'h0, VECS[i].exp_flag});
      check("R9 irq", {31'h0, irq}, {31'h0, VECS[i].exp_flag & VECS[i].ie});
    end

    // R8: writing 1 to the flag keeps it, writing 0 clears it
    wr(A_CTL, 32'h80);
    rd(A_CTL, d); check("R8 flag kept", d, 32'h80);
    wr(A_CTL, 32'h00);
    rd(A_CTL, d); check("R8 flag cleared", d, 32'h00);

    // R6: any data into the counter reloads the start value
    wr(A_STA, 32'h0000_0077);
    wr(A_CNT, 32'hFFFF_FFFF);
    rd(A_CNT, d); check("R6 count reload", d, 32'h77);

    // R2: zero extension and control field layout
    wr(A_LIM, 32'hABCD_5678);
    rd(A_LIM, d); check("R2 limit zero-ext", d, 32'h0000_5678);
    wr(A_CTL, 32'hFFFF_FFFF);
    rd(A_CTL, d); check("R2 ctrl fields", d, 32'h0000_005F);
    check("R9 irq no flag", {31'h0, irq}, 32'h0);

    // R5: source 2 does not count
    wr(A_CTL, 32'h10);
    idle(10);
    rd(A_CNT, d); check("R5 held count", d, 32'h77);

    // R7: limit write while source non-zero is held back
    wr(A_LIM, 32'h42);
    idle(2);
    rd(A_LIM, d); check("R7 limit not yet", d, 32'h5678);
    wr(A_CTL, 32'h00);
    idle(1);
    rd(A_LIM, d); check("R7 limit committed", d, 32'h42);

    // R10: control rewrite restarts the divider
    wr(A_STA, 32'h0);
    wr(A_LIM, 32'hFFFF);
    wr(A_CNT, 32'h0);
    wr(A_CTL, 32'h0A);
    idle(2);
    wr(A_CTL, 32'h0A);
    idle(1);
    rd(A_CNT, d); check("R10 no early count", d, 32'h0);
    idle(2);
    rd(A_CNT, d); check("R10 still waiting", d, 32'h0);
    idle(1);
    rd(A_CNT, d); check("R10 restarted period", d, 32'h1);

    // R9: enabling the interrupt with the flag already set
    wr(A_CTL, 32'h00);
    wr(A_LIM, 32'h0);
    wr(A_CNT, 32'h0);
    wr(A_CTL, 32'h08);
    idle(2);
    check("R9 irq masked", {31'h0, irq}, 32'h0);
    wr(A_CTL, 32'hC0);
    check("R9 irq raised", {31'h0, irq}, 32'h1);
    wr(A_CTL, 32'h40);
    check("R9 irq dropped", {31'h0, irq}, 32'h0);

    finish_run();
  end
endmodule